// File: doc/BRIEF.md
# Dual-Clock Frame Buffer with Restartable Pointers

This block is a frame store with two independent clock domains. A writer delivers 12-bit words on its own clock. A reader collects 12-bit words on a second clock. Each side keeps its own address pointer. The two domains share nothing except the storage array, and no pointer crosses between them. The array is a small on-chip memory of 2^MEM_AW words that stands in for bulk storage. Pointers wrap to zero after the last implemented address. A 24-bit address supplied with a pointer load is reduced to its low MEM_AW bits.

Either pointer can be restarted at any time. A clear control sends it to address zero. A load control sends it to an arbitrary 24-bit address. On the write side the restart acts on the same edge that captures the word, so that word lands at the new address. On the read side the restart begins a new fetch stream with a fixed latency: 9 enabled read edges after a clear and 14 after a load, counting the restart edge. After that, one consecutive word arrives on each enabled edge. Words still in flight at a restart are dropped. Until the first new word arrives, the output holds its last value and the valid strobe stays low.

The enables are active low and act as the stream handshake. The write enable marks a valid word, and every marked word is accepted, so the writer sees no back-pressure. The read enable is the reader's ready. While it is high, the read pipeline freezes, the output holds, and no word is presented. Each control pin is active low and, by default, acts only on a falling transition: it must be sampled high on one clock edge and low on a later one. A control acts only on an edge where its side's enable is active.

Top module: `fb_ptr_buffer`

## Requirements
- R1: Each write-clock edge with `wen_n` low and no restart stores `wdata` at the write pointer and advances the pointer by one. The pointer wraps from 2^MEM_AW-1 to 0.
- R2: A write clear on an enabled edge stores that edge's word at address 0, and the next word goes to address 1.
- R3: A write load on an enabled edge stores that edge's word at `waddr[MEM_AW-1:0]`, and the next word goes to the following address.
- R4: A read clear on an enabled read edge puts the word at address 0 on `rdata`, with `rvalid` high, right after the 9th enabled edge, counting the clear edge as the first. Each later enabled edge delivers the next address.
- R5: A read load to address A puts the word at A[MEM_AW-1:0] on `rdata`, with `rvalid` high, right after the 14th enabled edge, counting the load edge as the first. A+1 follows on the 15th.
- R6: A read restart drops all words in flight. Whenever `rvalid` is low, `rdata` keeps its previous value.
- R7: An edge with the side's enable high changes nothing. No word is stored, no pointer moves, and a clear or load seen on that edge is ignored. On the read side, `rvalid` is low after such an edge and `rdata` is unchanged.
- R8: When a clear and a load act on the same edge, the clear wins on both sides. On the read side the clear latency of R4 then applies.
- R9: A control held low across several enabled edges acts only on the first of them. It must return high before it can act again.
- R10: After reset `rdata` is 0, `rvalid` is 0 and both pointers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst_n | input | 1 | Write-domain asynchronous reset, active low |
| wen_n | input | 1 | Write enable (word valid), active low |
| wclr_n | input | 1 | Write pointer clear, active low |
| wset_n | input | 1 | Write pointer load, active low |
| waddr | input | 24 | Write load address |
| wdata | input | 12 | Write data word |
| rclk | input | 1 | Read clock |
| rrst_n | input | 1 | Read-domain asynchronous reset, active low |
| ren_n | input | 1 | Read enable (reader ready), active low |
| rclr_n | input | 1 | Read pointer clear, active low |
| rjmp_n | input | 1 | Read pointer load, active low |
| raddr | input | 24 | Read load address |
| rdata | output | 12 | Read data word |
| rvalid | output | 1 | High for one cycle after an enabled edge that delivered a new word |

## Verification
Results on the write side show up only through later reads. Every read result is due on an exact enabled-edge number. A fetch issued on the n-th enabled edge is due right after edge n+8. A clear edge issues a fetch itself, while a load edge is followed by four more bubble edges, which gives 9 and 14 edges counting the restart edge. The bench counts enabled read edges, stamps each expected word with its due edge number, and flushes its queue at every restart. A monitor samples on the falling clock edge, half a cycle after the edge that produced the output. It then checks that a word arrives exactly on its due edge with the expected data, and that `rdata` stays unchanged on every edge without a word.

// File: rtl/fb_pkg.sv
package fb_pkg;
  // How a pointer control pin is interpreted
  typedef enum logic {
    CTRL_LEVEL = 1'b0,  // acts on every enabled edge where the pin is low
    CTRL_FALL  = 1'b1   // acts once per high-to-low transition
  } ctrl_mode_e;
endpackage

// File: rtl/fb_ctrl_detect.sv
module fb_ctrl_detect #(
  parameter fb_pkg::ctrl_mode_e MODE = fb_pkg::CTRL_FALL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_n,
  output logic hit
);
  generate
    if (MODE == fb_pkg::CTRL_FALL) begin : g_fall
      logic prev_n;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_n <= 1'b1;
        else        prev_n <= sig_n;
      end
      assign hit = prev_n & ~sig_n;
    end else begin : g_level
      assign hit = ~sig_n;
    end
  endgenerate
endmodule

// File: rtl/fb_dual_mem.sv
module fb_dual_mem #(
  parameter int DW = 12,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rdata <= '0;
    else if (re)  rdata <= cells[raddr];
  end
endmodule

// File: rtl/fb_wr_side.sv
module fb_wr_side #(
  parameter int AW     = 8,
  parameter int EXT_AW = 24,
  parameter fb_pkg::ctrl_mode_e CLR_MODE = fb_pkg::CTRL_FALL,
  parameter fb_pkg::ctrl_mode_e SET_MODE = fb_pkg::CTRL_FALL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              clr_n,
  input  logic              set_n,
  input  logic [EXT_AW-1:0] load_addr,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr
);
  logic          en, clr_hit, set_hit;
  logic [AW-1:0] wptr;
  logic          unused_load_hi;

  assign unused_load_hi = ^load_addr[EXT_AW-1:AW];
  assign en = ~en_n;

  fb_ctrl_detect #(.MODE(CLR_MODE)) u_clr (
    .clk(clk), .rst_n(rst_n), .sig_n(clr_n), .hit(clr_hit));
  fb_ctrl_detect #(.MODE(SET_MODE)) u_set (
    .clk(clk), .rst_n(rst_n), .sig_n(set_n), .hit(set_hit));

  // clear outranks load; either redirects the word of this very edge
  always_comb begin
    if (clr_hit)      mem_addr = '0;
    else if (set_hit) mem_addr = load_addr[AW-1:0];
    else              mem_addr = wptr;
  end
  assign mem_we = en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  wptr <= '0;
    else if (en) wptr <= mem_addr + 1'b1;
  end

  // R1
  wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr_hit && !set_hit) |=> (wptr == AW'($past(wptr) + 1'b1)));
  // R3
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && set_hit && !clr_hit) |=> (wptr == AW'($past(load_addr[AW-1:0]) + 1'b1)));
  // R8
  wr_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_hit && set_hit) |=> (wptr == AW'(1)));
  // R7
  wr_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(wptr));
endmodule

// File: rtl/fb_rd_side.sv
module fb_rd_side #(
  parameter int AW       = 8,
  parameter int EXT_AW   = 24,
  parameter int CLR_LAT  = 9,
  parameter int JUMP_LAT = 14,
  parameter fb_pkg::ctrl_mode_e CLR_MODE = fb_pkg::CTRL_FALL,
  parameter fb_pkg::ctrl_mode_e JMP_MODE = fb_pkg::CTRL_FALL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              clr_n,
  input  logic              jmp_n,
  input  logic [EXT_AW-1:0] load_addr,
  output logic              mem_re,
  output logic [AW-1:0]     mem_raddr,
  output logic              rvalid
);
  // address stages ahead of the registered array read
  localparam int NST   = CLR_LAT - 1;
  // extra bubble edges a load costs over a clear
  localparam int SEEK  = JUMP_LAT - CLR_LAT;
  localparam int CNT_W = $clog2(SEEK + 1);

  logic             en, clr_hit, jmp_hit, restart;
  logic [AW-1:0]    rptr;
  logic [CNT_W-1:0] seek;
  logic [NST-1:0]   st_vld;
  logic [AW-1:0]    st_addr [NST];
  logic             unused_load_hi;

  assign unused_load_hi = ^load_addr[EXT_AW-1:AW];
  assign en = ~en_n;

  fb_ctrl_detect #(.MODE(CLR_MODE)) u_clr (
    .clk(clk), .rst_n(rst_n), .sig_n(clr_n), .hit(clr_hit));
  fb_ctrl_detect #(.MODE(JMP_MODE)) u_jmp (
    .clk(clk), .rst_n(rst_n), .sig_n(jmp_n), .hit(jmp_hit));

  assign restart   = clr_hit | jmp_hit;
  assign mem_re    = en & ~restart & st_vld[NST-1];
  assign mem_raddr = st_addr[NST-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr   <= '0;
      seek   <= '0;
      st_vld <= '0;
      rvalid <= 1'b0;
      for (int i = 0; i < NST; i++) st_addr[i] <= '0;
    end else if (en) begin
      if (clr_hit) begin
        st_vld     <= {{(NST-1){1'b0}}, 1'b1};
        st_addr[0] <= '0;
        rptr       <= AW'(1);
        seek       <= '0;
        rvalid     <= 1'b0;
      end else if (jmp_hit) begin
        st_vld <= '0;
        rptr   <= load_addr[AW-1:0];
        seek   <= CNT_W'(SEEK - 1);
        rvalid <= 1'b0;
      end else begin
        if (seek != '0) begin
          st_vld[0] <= 1'b0;
          seek      <= seek - 1'b1;
        end else begin
          st_vld[0]  <= 1'b1;
          st_addr[0] <= rptr;
          rptr       <= rptr + 1'b1;
        end
        for (int i = 1; i < NST; i++) begin
          st_vld[i]  <= st_vld[i-1];
          st_addr[i] <= st_addr[i-1];
        end
        rvalid <= st_vld[NST-1];
      end
    end else begin
      rvalid <= 1'b0;
    end
  end

  // R4
  rd_clear_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_hit) |=> (st_vld[0] && st_addr[0] == '0));
  // R5
  rd_seek_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && seek != '0) |=> !st_vld[0]);
  // R6
  rd_restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && restart) |=> !rvalid);
  // R7
  rd_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!rvalid && $stable(rptr) && $stable(st_vld)));
endmodule

// File: rtl/fb_ptr_buffer.sv
module fb_ptr_buffer #(
  parameter int DATA_W   = 12,
  parameter int EXT_AW   = 24,
  parameter int MEM_AW   = 8,
  parameter int CLR_LAT  = 9,
  parameter int JUMP_LAT = 14,
  parameter fb_pkg::ctrl_mode_e WCLR_MODE = fb_pkg::CTRL_FALL,
  parameter fb_pkg::ctrl_mode_e WSET_MODE = fb_pkg::CTRL_FALL,
  parameter fb_pkg::ctrl_mode_e RCLR_MODE = fb_pkg::CTRL_FALL,
  parameter fb_pkg::ctrl_mode_e RJMP_MODE = fb_pkg::CTRL_FALL
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wen_n,
  input  logic              wclr_n,
  input  logic              wset_n,
  input  logic [EXT_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              ren_n,
  input  logic              rclr_n,
  input  logic              rjmp_n,
  input  logic [EXT_AW-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic              mem_we, mem_re;
  logic [MEM_AW-1:0] mem_waddr, mem_raddr;

  fb_wr_side #(
    .AW(MEM_AW), .EXT_AW(EXT_AW), .CLR_MODE(WCLR_MODE), .SET_MODE(WSET_MODE)
  ) u_wr (
    .clk(wclk), .rst_n(wrst_n), .en_n(wen_n), .clr_n(wclr_n), .set_n(wset_n),
    .load_addr(waddr), .mem_we(mem_we), .mem_addr(mem_waddr));

  fb_rd_side #(
    .AW(MEM_AW), .EXT_AW(EXT_AW), .CLR_LAT(CLR_LAT), .JUMP_LAT(JUMP_LAT),
    .CLR_MODE(RCLR_MODE), .JMP_MODE(RJMP_MODE)
  ) u_rd (
    .clk(rclk), .rst_n(rrst_n), .en_n(ren_n), .clr_n(rclr_n), .jmp_n(rjmp_n),
    .load_addr(raddr), .mem_re(mem_re), .mem_raddr(mem_raddr), .rvalid(rvalid));

  fb_dual_mem #(.DW(DATA_W), .AW(MEM_AW)) u_mem (
    .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(wdata),
    .rclk(rclk), .rrst_n(rrst_n), .re(mem_re), .raddr(mem_raddr), .rdata(rdata));

  // R7
  rd_stall_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    ren_n |=> ($stable(rdata) && !rvalid));
  // R6
  rd_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rvalid |-> $stable(rdata));
endmodule

// File: tb/fb_ptr_buffer_bench.sv
module fb_ptr_buffer_bench;
  localparam int DW = 12;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n = 1'b0, rrst_n = 1'b0;
  logic wen_n = 1'b1, wclr_n = 1'b1, wset_n = 1'b1;
  logic ren_n = 1'b1, rclr_n = 1'b1, rjmp_n = 1'b1;
  logic [23:0] waddr = '0, raddr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid;

  always #2.5 wclk = ~wclk;
  initial begin #1.2; forever #2.5 rclk = ~rclk; end

  fb_ptr_buffer u_fb_ptr_buffer (
    .wclk(wclk), .wrst_n(wrst_n), .wen_n(wen_n), .wclr_n(wclr_n), .wset_n(wset_n),
    .waddr(waddr), .wdata(wdata), .rclk(rclk), .rrst_n(rrst_n), .ren_n(ren_n),
    .rclr_n(rclr_n), .rjmp_n(rjmp_n), .raddr(raddr), .rdata(rdata), .rvalid(rvalid));

  typedef struct {
    int          due;
    logic [DW-1:0] data;
    string       tag;
  } item_t;

  item_t         sb_q[$];
  logic [DW-1:0] model [DEPTH];
  string         atag  [DEPTH];
  int errors = 0, checks = 0;
  bit done = 0, mon_on = 0;

  // write-side model state
  logic [AW-1:0] m_wptr = '0;
  bit wprev_c = 1, wprev_s = 1;
  // read-side model state
  logic [AW-1:0] m_rptr = '0;
  int  m_seek = 0, ridx = 0;
  bit  rprev_c = 1, rprev_j = 1, last_en = 0;
  string next_tag = "";

  function automatic logic [DW-1:0] dat(int i);
    return DW'((i * 37 + 5) & 12'hFFF);
  endfunction

  task automatic wr_edge(bit en, bit clr, bit set, logic [23:0] a, logic [DW-1:0] d, string tag);
    logic [AW-1:0] dst;
    bit ch, sh;
    @(negedge wclk);
    wen_n = !en; wclr_n = !clr; wset_n = !set; waddr = a; wdata = d;
    @(posedge wclk);
    ch = wprev_c && clr; sh = wprev_s && set;
    wprev_c = !clr; wprev_s = !set;
    if (en) begin
      dst = ch ? '0 : (sh ? a[AW-1:0] : m_wptr);
      model[dst] = d;
      atag[dst] = tag;
      m_wptr = dst + 1'b1;
    end
  endtask

  task automatic push(logic [AW-1:0] adr);
    item_t it;
    it.due = ridx + 8;
    it.data = model[adr];
    it.tag = (next_tag != "") ? next_tag : atag[adr];
    next_tag = "";
    sb_q.push_back(it);
  endtask

  // driver: one read-clock edge, expected words pushed with their due edge
  task automatic rd_edge(bit en, bit clr, bit jmp, logic [23:0] a, string tag);
    bit ch, jh;
    @(negedge rclk);
    ren_n = !en; rclr_n = !clr; rjmp_n = !jmp; raddr = a;
    @(posedge rclk);
    ch = rprev_c && clr; jh = rprev_j && jmp;
    rprev_c = !clr; rprev_j = !jmp;
    last_en = en;
    if (en) begin
      ridx++;
      if (ch) begin
        sb_q.delete();
        m_seek = 0;
        next_tag = tag;
        push('0);
        m_rptr = AW'(1);
      end else if (jh) begin
        sb_q.delete();
        m_rptr = a[AW-1:0];
        m_seek = 4;
        next_tag = tag;
      end else if (m_seek > 0) begin
        m_seek--;
      end else begin
        push(m_rptr);
        m_rptr = m_rptr + 1'b1;
      end
    end
  endtask

  task automatic rd_run(int n);
    for (int i = 0; i < n; i++) rd_edge(1, 0, 0, '0, "");
  endtask

  // monitor: compares results half a cycle after the producing edge
  logic [DW-1:0] prev_rdata = '0;
  always @(negedge rclk) begin
    if (mon_on && !done) begin
      if (rvalid) begin
        checks++;
        if (sb_q.size() == 0) begin
          errors++;
          $display("FAIL R6: unexpected word rdata=%h at edge %0d, expected none", rdata, ridx);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          if (it.due != ridx || rdata !== it.data) begin
            errors++;
            $display("FAIL %s: rdata=%h at edge %0d, expected %h at edge %0d",
                     it.tag, rdata, ridx, it.data, it.due);
          end
        end
      end else begin
        checks++;
        if (rdata !== prev_rdata) begin
          errors++;
          $display("FAIL %s: rdata=%h without rvalid, expected held %h",
                   last_en ? "R6" : "R7", rdata, prev_rdata);
        end
        if (sb_q.size() != 0 && sb_q[0].due == ridx && last_en) begin
          errors++;
          $display("FAIL %s: rvalid=0 at edge %0d, expected word %h", sb_q[0].tag, ridx, sb_q[0].data);
          void'(sb_q.pop_front());
        end
      end
      prev_rdata = rdata;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) atag[i] = "R1";
    repeat (4) @(posedge wclk);
    @(negedge wclk); wrst_n = 1'b1;
    @(negedge rclk); rrst_n = 1'b1;
    #0.5;
    checks++;
    if (rdata !== '0 || rvalid !== 1'b0) begin
      errors++;
      $display("FAIL R10: rdata=%h rvalid=%b, expected 000 0", rdata, rvalid);
    end
    prev_rdata = rdata;
    mon_on = 1;

    // write phase
    for (int i = 0; i < DEPTH + 2; i++) wr_edge(1, 0, 0, '0, dat(i), "R1");
    wr_edge(1, 1, 0, '0, dat(1000), "R2");
    wr_edge(1, 0, 0, '0, dat(1001), "R2");
    wr_edge(1, 0, 1, 24'hABC040, dat(1002), "R3");
    wr_edge(1, 0, 0, '0, dat(1003), "R3");
    wr_edge(1, 1, 1, 24'h000080, dat(1004), "R8");
    wr_edge(1, 0, 0, '0, dat(1005), "R8");
    atag[8'h80] = "R8";
    wr_edge(1, 0, 1, 24'h000060, dat(1006), "R9");
    wr_edge(1, 0, 1, 24'h000070, dat(1007), "R9");
    atag[8'h70] = "R9";
    wr_edge(0, 1, 0, '0, 12'hBAD, "R7");
    wr_edge(1, 0, 0, '0, dat(1008), "R7");
    wr_edge(0, 0, 0, '0, '0, "");

    // read phase
    rd_edge(1, 1, 0, '0, "R4");
    rd_run(30);
    rd_edge(0, 1, 0, '0, "R7");
    rd_edge(0, 0, 0, '0, "");
    rd_edge(0, 0, 0, '0, "");
    rd_run(12);
    rd_edge(1, 0, 1, 24'hABC040, "R5");
    rd_run(70);
    rd_edge(1, 0, 1, 24'h12347E, "R5");
    rd_run(25);
    rd_edge(1, 0, 1, 24'h0000FD, "R5");
    rd_run(25);
    rd_edge(1, 0, 1, 24'h000010, "R9");
    rd_edge(1, 0, 1, 24'h000030, "");
    rd_edge(1, 0, 1, 24'h000030, "");
    rd_run(25);
    rd_edge(1, 0, 1, 24'h000050, "R5");
    rd_edge(1, 0, 0, '0, "");
    rd_edge(1, 1, 1, 24'h000050, "R8");
    rd_run(25);
    rd_edge(0, 0, 0, '0, "");
    @(negedge rclk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge rclk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule